// File: doc/BRIEF.md
# Operand Hazard Interlock for an In-Order Pipeline

This block decides, once per cycle, whether the instruction sitting in decode can move on to X1 in a single-issue, in-order pipeline with stages F, D, X1, X2, X3, X4 and W. It also tells the datapath where each source operand will come from. Every result can be bypassed from any later stage once it exists. A load's value exists only after its X3 stage and a multiply's value only after its X4 stage. A store reads its data operand in X2, so it may enter X1 before that data has been produced.

The controller records every instruction it lets into X1 in a small producer shift register. Each slot holds a destination tag and a ready-stage code, and the slots track X1 through W. For each source of the decode instruction it finds the youngest matching producer. It compares that producer's slot plus the consumer's need stage against the producer's ready stage, and it raises a stall while any source would arrive too late. During a stall, F and D keep their contents and a bubble goes into X1. When the instruction issues, each source gets a one-hot select that names the stage its producer will occupy in the consumer's need cycle.

Top module: `hz_interlock`

## Requirements
- R1: Once reset has been applied, no producer is in flight. An instruction with any source tags issues without stalling, and both selects point at the register file.
- R2: A load result (ready code 2, end of X3) stalls the instruction right behind it for 2 cycles when the operand is needed in X1 (need code 0), and for 1 cycle when it is needed in X2 (need code 1).
- R3: A multiply result (ready code 3, end of X4) stalls the next instruction for 3 cycles when needed in X1, and for 2 cycles when needed in X2 (store data).
- R4: A result with ready code 0 (end of X1) never stalls the next instruction. Its select is X2 when that instruction needs the value in X1, and X3 when it needs it in X2.
- R5: A cycle in which decode holds no valid instruction, or in which it stalls, puts no producer into X1. Later distances are counted from the cycle the producer really issued.
- R6: A select is one-hot: bit 0 register file, bit 1 X2, bit 2 X3, bit 3 X4, bit 4 W. It names the producer's stage in the cycle the consumer reaches its need stage. A producer that will have left W by then gives the register-file code.
- R7: When several in-flight producers write the tag a source reads, the youngest one decides both the stall and the select.
- R8: A source whose use flag is 0 never stalls and selects the register file. An instruction with its write flag at 0 is never treated as a producer.
- R9: Stall is high only while decode is valid, and it stays high while either source is hazarded. It never lasts more than 3 consecutive cycles.
- R10: The five-instruction loop (load, multiply, store, add-immediate, branch) issues its first instruction every 9 cycles in steady state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_valid_i | input | 1 | Decode holds an instruction |
| d_src_a_i | input | REG_W | Source A register tag |
| d_use_a_i | input | 1 | Source A is read |
| d_need_a_i | input | 1 | Source A need stage: 0 = X1, 1 = X2 |
| d_src_b_i | input | REG_W | Source B register tag |
| d_use_b_i | input | 1 | Source B is read |
| d_need_b_i | input | 1 | Source B need stage: 0 = X1, 1 = X2 |
| d_dst_i | input | REG_W | Destination register tag |
| d_wen_i | input | 1 | Instruction writes its destination |
| d_rdy_i | input | RDY_W | Result ready at end of: 0 X1, 1 X2, 2 X3, 3 X4 |
| stall_o | output | 1 | Hold F and D, send a bubble into X1 |
| issue_o | output | 1 | Decode instruction enters X1 at the next edge |
| fwd_a_o | output | N_SLOT | One-hot bypass select for source A |
| fwd_b_o | output | N_SLOT | One-hot bypass select for source B |

## Verification
Stall and both selects are combinational on the decode inputs and on the producer slots. They are due in the same cycle an instruction is presented, and the slots advance one stage at each rising edge. The bench drives each instruction just after a falling edge and samples shortly after. It counts how many consecutive cycles stall stays high, and it takes the selects in the first cycle stall is low, which is the issue cycle. Every expected stall count and select is worked out from ready stage minus (slot + need) in the cycle each instruction is presented.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // need-stage codes
  localparam logic NEED_X1 = 1'b0;
  localparam logic NEED_X2 = 1'b1;

  // A producer in slot 'slot' (0 = X1) can feed a consumer that is in D now
  // and needs the value at the start of stage 'need' (0 = X1), provided it
  // has finished stage 'rdy' by then.
  function automatic bit fwd_ready(int slot, int need, int rdy);
    return (slot + need) >= rdy;
  endfunction

  // Slot the producer occupies when the consumer reaches its need stage.
  function automatic int fwd_pos(int slot, int need);
    return slot + 1 + need;
  endfunction

endpackage

// File: rtl/hz_track.sv
module hz_track #(
  parameter int REG_W  = 5,
  parameter int N_SLOT = 5,
  parameter int RDY_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic [REG_W-1:0] dst_i,
  input  logic             wen_i,
  input  logic [RDY_W-1:0] rdy_i,
  output logic             slot_vld_o [N_SLOT],
  output logic [REG_W-1:0] slot_dst_o [N_SLOT],
  output logic [RDY_W-1:0] slot_rdy_o [N_SLOT]
);

  logic             vld_q [N_SLOT];
  logic [REG_W-1:0] dst_q [N_SLOT];
  logic [RDY_W-1:0] rdy_q [N_SLOT];
  logic             entering;

  assign entering = push_i & wen_i;

  // slot 0 = X1, loaded only by an issuing writer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q[0] <= 1'b0;
      dst_q[0] <= '0;
      rdy_q[0] <= '0;
    end else begin
      vld_q[0] <= entering;
      dst_q[0] <= dst_i;
      rdy_q[0] <= rdy_i;
    end
  end

  // execute stages never stall: every later slot copies the one before it
  for (genvar k = 1; k < N_SLOT; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[k] <= 1'b0;
        dst_q[k] <= '0;
        rdy_q[k] <= '0;
      end else begin
        vld_q[k] <= vld_q[k-1];
        dst_q[k] <= dst_q[k-1];
        rdy_q[k] <= rdy_q[k-1];
      end
    end

    // R5
    track_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q[k] == $past(vld_q[k-1]));
  end

  for (genvar k = 0; k < N_SLOT; k++) begin : g_out
    assign slot_vld_o[k] = vld_q[k];
    assign slot_dst_o[k] = dst_q[k];
    assign slot_rdy_o[k] = rdy_q[k];
  end

  // R5
  no_push_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> !vld_q[0]);

endmodule

// File: rtl/hz_operand.sv
module hz_operand #(
  parameter int REG_W  = 5,
  parameter int N_SLOT = 5,
  parameter int RDY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              use_i,
  input  logic [REG_W-1:0]  src_i,
  input  logic              need_i,
  input  logic              slot_vld_i [N_SLOT],
  input  logic [REG_W-1:0]  slot_dst_i [N_SLOT],
  input  logic [RDY_W-1:0]  slot_rdy_i [N_SLOT],
  output logic              hazard_o,
  output logic [N_SLOT-1:0] sel_o
);

  localparam int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1;

  logic              hit;
  logic [SLOT_W-1:0] hit_slot;
  logic [RDY_W-1:0]  hit_rdy;
  logic              in_time;
  logic              from_pipe;
  int                pos;

  // scan oldest to youngest so the youngest match is left standing (R7)
  always_comb begin
    hit      = 1'b0;
    hit_slot = '0;
    for (int k = N_SLOT - 1; k >= 0; k--) begin
      if (slot_vld_i[k] && (slot_dst_i[k] == src_i)) begin
        hit      = 1'b1;
        hit_slot = SLOT_W'(k);
      end
    end
  end

  assign hit_rdy   = slot_rdy_i[hit_slot];
  assign in_time   = hz_pkg::fwd_ready(int'(hit_slot), int'(need_i), int'(hit_rdy));
  assign pos       = hz_pkg::fwd_pos(int'(hit_slot), int'(need_i));
  assign hazard_o  = use_i & hit & ~in_time;
  assign from_pipe = use_i & hit & (pos < N_SLOT);

  always_comb begin
    sel_o = '0;
    for (int k = 1; k < N_SLOT; k++) begin
      sel_o[k] = from_pipe & (pos == k);
    end
    sel_o[0] = ~from_pipe;
  end

  // R6
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel_o) == 1);

  // R8
  unused_no_hazard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !use_i |-> (!hazard_o && sel_o[0]));

endmodule

// File: rtl/hz_interlock.sv
module hz_interlock #(
  parameter int REG_W  = 5,
  parameter int N_SLOT = 5,
  parameter int RDY_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_valid_i,
  input  logic [REG_W-1:0]  d_src_a_i,
  input  logic              d_use_a_i,
  input  logic              d_need_a_i,
  input  logic [REG_W-1:0]  d_src_b_i,
  input  logic              d_use_b_i,
  input  logic              d_need_b_i,
  input  logic [REG_W-1:0]  d_dst_i,
  input  logic              d_wen_i,
  input  logic [RDY_W-1:0]  d_rdy_i,
  output logic              stall_o,
  output logic              issue_o,
  output logic [N_SLOT-1:0] fwd_a_o,
  output logic [N_SLOT-1:0] fwd_b_o
);

  localparam int MAX_STALL = (1 << RDY_W) - 1;
  localparam int RUN_W     = RDY_W + 2;

  logic             slot_vld [N_SLOT];
  logic [REG_W-1:0] slot_dst [N_SLOT];
  logic [RDY_W-1:0] slot_rdy [N_SLOT];
  logic             haz_a, haz_b;
  logic [RUN_W-1:0] stall_run;

  hz_track #(.REG_W(REG_W), .N_SLOT(N_SLOT), .RDY_W(RDY_W)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (issue_o),
    .dst_i      (d_dst_i),
    .wen_i      (d_wen_i),
    .rdy_i      (d_rdy_i),
    .slot_vld_o (slot_vld),
    .slot_dst_o (slot_dst),
    .slot_rdy_o (slot_rdy)
  );

  hz_operand #(.REG_W(REG_W), .N_SLOT(N_SLOT), .RDY_W(RDY_W)) u_opa (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_i      (d_use_a_i),
    .src_i      (d_src_a_i),
    .need_i     (d_need_a_i),
    .slot_vld_i (slot_vld),
    .slot_dst_i (slot_dst),
    .slot_rdy_i (slot_rdy),
    .hazard_o   (haz_a),
    .sel_o      (fwd_a_o)
  );

  hz_operand #(.REG_W(REG_W), .N_SLOT(N_SLOT), .RDY_W(RDY_W)) u_opb (
    .clk        (clk),
    .rst_n      (rst_n),
    .use_i      (d_use_b_i),
    .src_i      (d_src_b_i),
    .need_i     (d_need_b_i),
    .slot_vld_i (slot_vld),
    .slot_dst_i (slot_dst),
    .slot_rdy_i (slot_rdy),
    .hazard_o   (haz_b),
    .sel_o      (fwd_b_o)
  );

  assign stall_o = d_valid_i & (haz_a | haz_b);
  assign issue_o = d_valid_i & ~stall_o;

  // consecutive stall cycles already spent on the current decode instruction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_run <= '0;
    end else if (!stall_o) begin
      stall_run <= '0;
    end else if (stall_run != {RUN_W{1'b1}}) begin
      stall_run <= stall_run + 1'b1;
    end
  end

  // R9
  stall_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> d_valid_i);

  // R9
  stall_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> (int'(stall_run) < MAX_STALL));

  // R5
  stall_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |=> !slot_vld[0]);

endmodule

// File: tb/tb_hz_interlock.sv
module tb_hz_interlock;

  localparam int REG_W = 5;
  localparam int NS    = 5;
  localparam int RDY_W = 2;
  localparam logic [NS-1:0] RF = 5'b00001;
  localparam logic [NS-1:0] X2 = 5'b00010;
  localparam logic [NS-1:0] X3 = 5'b00100;
  localparam logic [NS-1:0] X4 = 5'b01000;
  localparam logic [NS-1:0] WB = 5'b10000;

  typedef struct packed {
    logic             vld;
    logic [REG_W-1:0] a;
    logic             ua;
    logic             na;
    logic [REG_W-1:0] b;
    logic             ub;
    logic             nb;
    logic [REG_W-1:0] dst;
    logic             wen;
    logic [RDY_W-1:0] rdy;
    logic [1:0]       est;
    logic [NS-1:0]    esa;
    logic [NS-1:0]    esb;
  } ent_t;

  localparam int NE = 29;
  // vld, a, ua, na, b, ub, nb, dst, wen, rdy, stalls, sel_a, sel_b
  localparam ent_t TAB [NE] = '{
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd16, 1'b1, 2'd2, 2'd0, RF, RF}, // 0 load
    '{1'b1, 5'd18, 1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 5'd16, 1'b1, 2'd3, 2'd2, RF, X4}, // 1 mul
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 5'd0,  1'b0, 2'd0, 2'd2, RF, WB}, // 2 store
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd1,  1'b1, 2'd0, 2'd0, RF, RF}, // 3 addi
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd2,  1'b1, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, X2, RF}, // 4 branch
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd16, 1'b1, 2'd2, 2'd0, X3, RF}, // 5 load
    '{1'b1, 5'd18, 1'b1, 1'b0, 5'd16, 1'b1, 1'b0, 5'd16, 1'b1, 2'd3, 2'd2, RF, X4}, // 6 mul
    '{1'b1, 5'd1,  1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 5'd0,  1'b0, 2'd0, 2'd2, RF, WB}, // 7 store
    '{1'b1, 5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd3,  1'b1, 2'd0, 2'd0, RF, RF}, // 8
    '{1'b1, 5'd3,  1'b1, 1'b0, 5'd3,  1'b1, 1'b1, 5'd0,  1'b0, 2'd0, 2'd0, X2, X3}, // 9
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd4,  1'b1, 2'd0, 2'd0, RF, RF}, // 10
    '{1'b1, 5'd4,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd4,  1'b1, 2'd0, 2'd0, X2, RF}, // 11
    '{1'b1, 5'd4,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, X2, RF}, // 12
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd20, 1'b1, 2'd2, 2'd0, RF, RF}, // 13
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd21, 1'b1, 2'd3, 2'd0, RF, RF}, // 14
    '{1'b1, 5'd20, 1'b1, 1'b0, 5'd21, 1'b1, 1'b0, 5'd0,  1'b0, 2'd0, 2'd3, RF, WB}, // 15
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd5,  1'b0, 2'd3, 2'd0, RF, RF}, // 16
    '{1'b1, 5'd5,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, RF, RF}, // 17
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd6,  1'b1, 2'd2, 2'd0, RF, RF}, // 18
    '{1'b1, 5'd6,  1'b0, 1'b0, 5'd6,  1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, RF, RF}, // 19
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 2'd2, 2'd0, RF, RF}, // 20
    '{1'b1, 5'd7,  1'b1, 1'b1, 5'd0,  1'b0, 1'b0, 5'd8,  1'b1, 2'd0, 2'd1, X4, RF}, // 21
    '{1'b1, 5'd7,  1'b1, 1'b0, 5'd8,  1'b1, 1'b0, 5'd0,  1'b0, 2'd0, 2'd0, X4, X2}, // 22
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd10, 1'b1, 2'd2, 2'd0, RF, RF}, // 23
    '{1'b1, 5'd10, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd11, 1'b1, 2'd3, 2'd2, X4, RF}, // 24
    '{1'b1, 5'd11, 1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd3, WB, RF}, // 25
    '{1'b1, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 2'd3, 2'd0, RF, RF}, // 26
    '{1'b0, 5'd9,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd9,  1'b1, 2'd3, 2'd0, RF, RF}, // 27 idle
    '{1'b1, 5'd9,  1'b1, 1'b0, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 2'd0, 2'd2, WB, RF}  // 28
  };

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             d_valid;
  logic [REG_W-1:0] d_src_a, d_src_b, d_dst;
  logic             d_use_a, d_need_a, d_use_b, d_need_b, d_wen;
  logic [RDY_W-1:0] d_rdy;
  logic             stall_o, issue_o;
  logic [NS-1:0]    fwd_a_o, fwd_b_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int issue_cyc [NE];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hz_interlock #(.REG_W(REG_W), .N_SLOT(NS), .RDY_W(RDY_W)) dut (
    .clk(clk), .rst_n(rst_n), .d_valid_i(d_valid),
    .d_src_a_i(d_src_a), .d_use_a_i(d_use_a), .d_need_a_i(d_need_a),
    .d_src_b_i(d_src_b), .d_use_b_i(d_use_b), .d_need_b_i(d_need_b),
    .d_dst_i(d_dst), .d_wen_i(d_wen), .d_rdy_i(d_rdy),
    .stall_o(stall_o), .issue_o(issue_o), .fwd_a_o(fwd_a_o), .fwd_b_o(fwd_b_o)
  );

  function automatic string req_of(int i);
    case (i)
      1, 6, 21, 24: return "R2";
      2, 7, 25:     return "R3";
      4, 9, 11:     return "R4";
      22, 28:       return "R5";
      0, 5:         return "R6";
      12:           return "R7";
      15, 27:       return "R9";
      default:      return "R8";
    endcase
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic drive(ent_t e);
    d_valid = e.vld; d_src_a = e.a; d_use_a = e.ua; d_need_a = e.na;
    d_src_b = e.b; d_use_b = e.ub; d_need_b = e.nb;
    d_dst = e.dst; d_wen = e.wen; d_rdy = e.rdy;
  endtask

  task automatic run_ent(int i);
    int st = 0;
    ent_t e = TAB[i];
    @(negedge clk);
    drive(e);
    #1;
    if (!e.vld) begin
      check(req_of(i), $sformatf("entry %0d stall while idle", i), int'(stall_o), 0);
    end else begin
      while (stall_o && st < 8) begin
        st++;
        @(negedge clk);
        #1;
      end
      issue_cyc[i] = cyc;
      check(req_of(i), $sformatf("entry %0d stall cycles", i), st, int'(e.est));
      check(req_of(i), $sformatf("entry %0d select A", i), int'(fwd_a_o), int'(e.esa));
      check(req_of(i), $sformatf("entry %0d select B", i), int'(fwd_b_o), int'(e.esb));
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing in flight after reset
    drive('{1'b1, 5'd16, 1'b1, 1'b0, 5'd16, 1'b1, 1'b1, 5'd0, 1'b0, 2'd0, 2'd0, RF, RF});
    #1;
    check("R1", "stall after reset", int'(stall_o), 0);
    check("R1", "select A after reset", int'(fwd_a_o), int'(RF));
    check("R1", "select B after reset", int'(fwd_b_o), int'(RF));

    for (int i = 0; i < NE; i++) run_ent(i);

    // R10: loop period from first load issue to second load issue
    check("R10", "loop cycles per iteration", issue_cyc[5] - issue_cyc[0], 9);

    // R1: reset while a load is in flight clears it
    @(negedge clk);
    drive('{1'b1, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 1'b0, 5'd30, 1'b1, 2'd2, 2'd0, RF, RF});
    @(negedge clk);
    d_valid = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive('{1'b1, 5'd30, 1'b1, 1'b0, 5'd0, 1'b0, 1'b0, 5'd0, 1'b0, 2'd0, 2'd0, RF, RF});
    #1;
    check("R1", "stall after mid-run reset", int'(stall_o), 0);
    check("R1", "select A after mid-run reset", int'(fwd_a_o), int'(RF));
    @(negedge clk);
    d_valid = 1'b0;
    summary();
    $finish;
  end

endmodule